// File: doc/BRIEF.md
# Dual Serial Channel Control Logic

This block keeps the host-visible control and status state for two identical serial channels behind a byte-wide register bus. Each channel has a command register, a status register and a shared data location. A write to the data location hands a byte to the transmit side, and a read from it takes the held received byte. The line side of each channel is a byte-level stub. A strobe with a byte comes in when a character has arrived. A strobe with a byte goes out when the host has written one. Bit timing, framing and rate generation are not part of this block.

The command register carries two independent two-bit fields, one for the receiver and one for the transmitter. Each field can enable, disable or leave its half alone. Data accesses clear the interrupt source they satisfy. Each channel also gives one-cycle event pulses, so that a parent interrupt block can latch receive and transmit events.

Top module: `duo_chan_ctrl`

## Requirements
- R1: After reset, both status bytes read 0x00, both channels are disabled, and every interrupt flag, pulse and transmit strobe output is 0.
- R2: Address bit 4 selects the channel (0 = first, 1 = second). Within a channel, low offset 0x3 reads status, 0x5 takes command writes, and 0x7 takes transmit writes and returns the held byte on reads. Any other address reads 0x00, and writes to it change nothing.
- R3: Command bits [1:0] drive the receiver: 01 enables it, 10 disables it, and 00 or 11 leave it as it was.
- R4: Command bits [3:2] drive the transmitter. 01 enables it and sets transmitter ready, transmitter empty and the transmit interrupt flag. 10 disables it and clears all three. 00 or 11 leave it as it was.
- R5: Status bit 0 is receiver ready, bit 1 is holding full (always equal to bit 0, because the holding store is one byte deep), bit 2 is transmitter ready and bit 3 is transmitter empty. Bits 7:4 are error flags and always read 0.
- R6: A line byte is accepted only while the receiver is enabled and receiver ready is clear. Acceptance stores the byte, sets receiver ready and the receive interrupt flag, and pulses the receive interrupt output for one cycle. A byte that is not accepted leaves the held byte and all flags unchanged.
- R7: A read of the data location returns the held byte. After that edge, receiver ready and the receive interrupt flag are clear.
- R8: A write of the data location drives the transmit strobe high for exactly one cycle after the write edge, with the written byte, whether or not the transmitter is enabled. For that cycle, transmitter ready, transmitter empty and the transmit interrupt flag read 0.
- R9: While the transmitter is enabled, transmitter ready, transmitter empty and the transmit interrupt flag are set again on the next edge. The transmit interrupt output pulses for one cycle each time transmitter ready goes from 0 to 1.
- R10: Accesses and line events on one channel leave the other channel's status, held byte and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Register address |
| busWrEn | input | 1 | Write strobe for this cycle |
| busRdEn | input | 1 | Read strobe for this cycle (side effects only) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from busAddr |
| lineRxValid | input | 2 | Per-channel received-byte strobe |
| lineRxByte | input | 16 | Received bytes, channel 0 in [7:0] |
| lineTxStrobe | output | 2 | Per-channel transmit strobe |
| lineTxByte | output | 16 | Transmitted bytes, channel 0 in [7:0] |
| rxIrqFlag | output | 2 | Receive interrupt flag per channel |
| txIrqFlag | output | 2 | Transmit interrupt flag per channel |
| rxIrqPulse | output | 2 | One-cycle pulse on byte acceptance |
| txIrqPulse | output | 2 | One-cycle pulse when transmitter ready rises |

## Verification
Read data is combinational, so the status and the held byte are sampled in the same cycle as the address, with no edge between. Each command, line byte and data access takes effect at the first rising edge it sees. The bench therefore drives at a falling edge and checks flags, strobes and receive pulses at the next falling edge. The transmitter's recovery after a data write is due one edge later, together with its pulse, and the bench checks that after one more falling edge. The command sweep applies every 4-bit command value to all four prior enable states on both channels.

// File: rtl/duo_chan_pkg.sv
package duo_chan_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 4;

  // Offsets inside one channel window; the decoder compares against these.
  localparam logic [OFS_W-1:0] OFS_STATUS = 4'h3;
  localparam logic [OFS_W-1:0] OFS_CMD    = 4'h5;
  localparam logic [OFS_W-1:0] OFS_DATA   = 4'h7;

  // Two-bit enable/disable field encoding.
  typedef enum logic [1:0] {
    FLD_HOLD0 = 2'b00,
    FLD_ON    = 2'b01,
    FLD_OFF   = 2'b10,
    FLD_HOLD3 = 2'b11
  } fieldCmd_t;

  // Strobes from the decoder to one channel lane.
  typedef struct packed {
    logic cmdWr;
    logic txWr;
    logic rxRd;
  } chanStrobe_t;
endpackage

// File: rtl/duo_chan_decode.sv
module duo_chan_decode
  import duo_chan_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CH_COUNT = 2
) (
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic                             busWrEn,
  input  logic                             busRdEn,
  output chanStrobe_t [CH_COUNT-1:0]       strobes,
  output logic [CH_COUNT-1:0]              statusHit,
  output logic [CH_COUNT-1:0]              dataHit
);
  localparam int CH_BITS = ADDR_W - OFS_W;

  logic [OFS_W-1:0]   ofs;
  logic [CH_BITS-1:0] chSel;

  assign ofs   = busAddr[OFS_W-1:0];
  assign chSel = busAddr[ADDR_W-1:OFS_W];

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_ch
    logic chHit;
    assign chHit            = (chSel == CH_BITS'(c));
    assign statusHit[c]     = chHit && (ofs == OFS_STATUS);
    assign dataHit[c]       = chHit && (ofs == OFS_DATA);
    assign strobes[c].cmdWr = chHit && busWrEn && (ofs == OFS_CMD);
    assign strobes[c].txWr  = chHit && busWrEn && (ofs == OFS_DATA);
    assign strobes[c].rxRd  = chHit && busRdEn && (ofs == OFS_DATA);
  end
endmodule

// File: rtl/duo_chan_lane.sv
module duo_chan_lane
  import duo_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanStrobe_t       strobe,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] holdByte,
  output logic              txStrobe,
  output logic [BYTE_W-1:0] txByte,
  output logic              rxIrqFlag,
  output logic              txIrqFlag,
  output logic              rxIrqPulse,
  output logic              txIrqPulse
);
  logic      rxEn, txEn, rxRdy, txRdy, txFlagQ;
  fieldCmd_t rxCmd, txCmd;
  logic      rxOn, rxOff, txOn, txOff;
  logic      accept, txRdyNext, txFlagNext;

  assign rxCmd = fieldCmd_t'(wrData[1:0]);
  assign txCmd = fieldCmd_t'(wrData[3:2]);
  assign rxOn  = strobe.cmdWr && (rxCmd == FLD_ON);
  assign rxOff = strobe.cmdWr && (rxCmd == FLD_OFF);
  assign txOn  = strobe.cmdWr && (txCmd == FLD_ON);
  assign txOff = strobe.cmdWr && (txCmd == FLD_OFF);

  // Receiver takes a byte only into an empty holding store.
  assign accept = rxValid && rxEn && !rxRdy;

  always_comb begin
    if (txOn)             txRdyNext = 1'b1;
    else if (txOff)       txRdyNext = 1'b0;
    else if (strobe.txWr) txRdyNext = 1'b0;
    else                  txRdyNext = txEn;
  end

  always_comb begin
    if (txOn)             txFlagNext = 1'b1;
    else if (txOff)       txFlagNext = 1'b0;
    else if (strobe.txWr) txFlagNext = 1'b0;
    else if (txEn)        txFlagNext = 1'b1;
    else                  txFlagNext = txFlagQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEn       <= 1'b0;
      txEn       <= 1'b0;
      rxRdy      <= 1'b0;
      txRdy      <= 1'b0;
      txFlagQ    <= 1'b0;
      holdByte   <= '0;
      txStrobe   <= 1'b0;
      txByte     <= '0;
      rxIrqPulse <= 1'b0;
      txIrqPulse <= 1'b0;
    end else begin
      if (rxOn)       rxEn <= 1'b1;
      else if (rxOff) rxEn <= 1'b0;
      if (txOn)       txEn <= 1'b1;
      else if (txOff) txEn <= 1'b0;

      if (accept) begin
        rxRdy    <= 1'b1;
        holdByte <= rxByte;
      end else if (strobe.rxRd) begin
        rxRdy    <= 1'b0;
      end

      txRdy      <= txRdyNext;
      txFlagQ    <= txFlagNext;
      txStrobe   <= strobe.txWr;
      if (strobe.txWr) txByte <= wrData;
      rxIrqPulse <= accept;
      txIrqPulse <= txRdyNext && !txRdy;
    end
  end

  // The receive interrupt source tracks the one-deep holding store.
  assign rxIrqFlag  = rxRdy;
  assign txIrqFlag  = txFlagQ;
  assign statusByte = {4'b0000, txRdy, txRdy, rxRdy, rxRdy};
endmodule

// File: rtl/duo_chan_ctrl.sv
module duo_chan_ctrl
  import duo_chan_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CH_COUNT = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [BYTE_W-1:0]            busWrData,
  output logic [BYTE_W-1:0]            busRdData,
  input  logic [CH_COUNT-1:0]          lineRxValid,
  input  logic [CH_COUNT*BYTE_W-1:0]   lineRxByte,
  output logic [CH_COUNT-1:0]          lineTxStrobe,
  output logic [CH_COUNT*BYTE_W-1:0]   lineTxByte,
  output logic [CH_COUNT-1:0]          rxIrqFlag,
  output logic [CH_COUNT-1:0]          txIrqFlag,
  output logic [CH_COUNT-1:0]          rxIrqPulse,
  output logic [CH_COUNT-1:0]          txIrqPulse
);
  chanStrobe_t [CH_COUNT-1:0]           strobes;
  logic [CH_COUNT-1:0]                  statusHit, dataHit;
  logic [CH_COUNT-1:0][BYTE_W-1:0]      statusBus, holdBus;

  duo_chan_decode #(.ADDR_W(ADDR_W), .CH_COUNT(CH_COUNT)) u_dec (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .strobes  (strobes),
    .statusHit(statusHit),
    .dataHit  (dataHit)
  );

  for (genvar c = 0; c < CH_COUNT; c++) begin : g_lane
    duo_chan_lane u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .strobe    (strobes[c]),
      .wrData    (busWrData),
      .rxValid   (lineRxValid[c]),
      .rxByte    (lineRxByte[c*BYTE_W +: BYTE_W]),
      .statusByte(statusBus[c]),
      .holdByte  (holdBus[c]),
      .txStrobe  (lineTxStrobe[c]),
      .txByte    (lineTxByte[c*BYTE_W +: BYTE_W]),
      .rxIrqFlag (rxIrqFlag[c]),
      .txIrqFlag (txIrqFlag[c]),
      .rxIrqPulse(rxIrqPulse[c]),
      .txIrqPulse(txIrqPulse[c])
    );
  end

  always_comb begin
    busRdData = '0;
    for (int c = 0; c < CH_COUNT; c++) begin
      if (statusHit[c]) busRdData = statusBus[c];
      if (dataHit[c])   busRdData = holdBus[c];
    end
  end
endmodule

// File: rtl/duo_chan_ctrl_chk.sv
module duo_chan_ctrl_chk
  import duo_chan_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int CH_COUNT = 2
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busWrEn,
  input logic                         busRdEn,
  input logic [BYTE_W-1:0]            busWrData,
  input logic [BYTE_W-1:0]            busRdData,
  input logic [CH_COUNT-1:0]          lineRxValid,
  input logic [CH_COUNT*BYTE_W-1:0]   lineTxByte,
  input logic [CH_COUNT-1:0]          lineTxStrobe,
  input logic [CH_COUNT-1:0]          rxIrqFlag,
  input logic [CH_COUNT-1:0]          rxIrqPulse,
  input logic [CH_COUNT-1:0]          txIrqPulse
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] B_STATUS = ADDR_W'(16 + 32'(OFS_STATUS));
  localparam logic [ADDR_W-1:0] B_DATA   = ADDR_W'(16 + 32'(OFS_DATA));

  assert_tx_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_DATA) |=> (lineTxStrobe[0] && lineTxByte[BYTE_W-1:0] == $past(busWrData)));

  assert_rx_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == B_DATA) |=> !rxIrqFlag[1]);

  assert_err_bits_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == A_STATUS || busAddr == B_STATUS) |-> (busRdData[7:4] == 4'h0));

  assert_rx_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrqPulse[0] |-> $past(lineRxValid[0]));

  assert_rx_flag_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrqFlag[1]) |-> rxIrqPulse[1]);

  assert_tx_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    txIrqPulse[1] |=> !txIrqPulse[1]);
endmodule

bind duo_chan_ctrl duo_chan_ctrl_chk #(.ADDR_W(ADDR_W), .CH_COUNT(CH_COUNT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busWrData   (busWrData),
  .busRdData   (busRdData),
  .lineRxValid (lineRxValid),
  .lineTxByte  (lineTxByte),
  .lineTxStrobe(lineTxStrobe),
  .rxIrqFlag   (rxIrqFlag),
  .rxIrqPulse  (rxIrqPulse),
  .txIrqPulse  (txIrqPulse)
);

// File: tb/sim_duo_chan_ctrl.sv
`timescale 1ns/1ps
module sim_duo_chan_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [1:0]  lineRxValid = '0;
  logic [15:0] lineRxByte = '0;
  logic [1:0]  lineTxStrobe;
  logic [15:0] lineTxByte;
  logic [1:0]  rxIrqFlag, txIrqFlag, rxIrqPulse, txIrqPulse;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  duo_chan_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .lineRxValid(lineRxValid),
    .lineRxByte(lineRxByte), .lineTxStrobe(lineTxStrobe), .lineTxByte(lineTxByte),
    .rxIrqFlag(rxIrqFlag), .txIrqFlag(txIrqFlag), .rxIrqPulse(rxIrqPulse),
    .txIrqPulse(txIrqPulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] adr(input int ch, input logic [3:0] ofs);
    return {ch[0], ofs};
  endfunction

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 5'h00;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0; busAddr = 5'h00;
  endtask

  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
    busAddr = 5'h00;
  endtask

  task automatic pushRx(input int ch, input logic [7:0] b);
    @(negedge clk);
    lineRxValid[ch] = 1'b1; lineRxByte[ch*8 +: 8] = b;
    @(negedge clk);
    lineRxValid = '0;
  endtask

  function automatic logic fieldNext(input logic [1:0] f, input logic prev);
    return (f == 2'b01) ? 1'b1 : (f == 2'b10) ? 1'b0 : prev;
  endfunction

  initial begin
    #(100000 * 5);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(adr(0, 4'h3), d); chk("R1 status A", d, 8'h00);
    peek(adr(1, 4'h3), d); chk("R1 status B", d, 8'h00);
    chk("R1 outputs", {lineTxStrobe, rxIrqFlag, txIrqFlag, rxIrqPulse, txIrqPulse}, 10'h0);
    rstN = 1'b1;
    @(negedge clk);
    peek(adr(0, 4'h3), d); chk("R1 status A after release", d, 8'h00);

    // R2 unmapped addresses: writes ignored, reads zero
    busWrite(5'h04, 8'h05);
    busWrite(5'h06, 8'h05);
    busWrite(5'h1F, 8'h05);
    peek(adr(0, 4'h3), d); chk("R2 unmapped write A", d, 8'h00);
    peek(adr(1, 4'h3), d); chk("R2 unmapped write B", d, 8'h00);
    chk("R2 unmapped write strobe", lineTxStrobe, 2'b00);
    peek(5'h15, d); chk("R2 command location reads zero", d, 8'h00);

    // R4 R9 transmitter enable on A
    busWrite(adr(0, 4'h5), 8'h04);
    peek(adr(0, 4'h3), d); chk("R4 tx enable status", d, 8'h0C);
    chk("R4 tx flag set", txIrqFlag, 2'b01);
    chk("R9 pulse on enable", txIrqPulse, 2'b01);
    peek(adr(1, 4'h3), d); chk("R10 B untouched by A enable", d, 8'h00);
    @(negedge clk);
    chk("R9 pulse single", txIrqPulse, 2'b00);

    // R8 transmit write and R9 recovery
    busWrite(adr(0, 4'h7), 8'hA5);
    chk("R8 strobe", lineTxStrobe, 2'b01);
    chk("R8 byte", lineTxByte[7:0], 8'hA5);
    peek(adr(0, 4'h3), d); chk("R8 ready cleared", d, 8'h00);
    chk("R8 tx flag cleared", txIrqFlag, 2'b00);
    @(negedge clk);
    chk("R8 strobe one cycle", lineTxStrobe, 2'b00);
    peek(adr(0, 4'h3), d); chk("R9 ready back", d, 8'h0C);
    chk("R9 tx flag back", txIrqFlag, 2'b01);
    chk("R9 pulse on recovery", txIrqPulse, 2'b01);
    @(negedge clk);
    chk("R9 pulse ends", txIrqPulse, 2'b00);

    // R8 write on disabled transmitter (B)
    busWrite(adr(1, 4'h7), 8'h3C);
    chk("R8 strobe while disabled", lineTxStrobe, 2'b10);
    chk("R8 byte B", lineTxByte[15:8], 8'h3C);
    @(negedge clk);
    peek(adr(1, 4'h3), d); chk("R8 disabled stays not ready", d, 8'h00);

    // R6 R7 receive path on A
    busWrite(adr(0, 4'h5), 8'h01);
    pushRx(0, 8'h11);
    peek(adr(0, 4'h3), d); chk("R6 ready after accept", d & 8'h03, 8'h03);
    chk("R6 rx flag", rxIrqFlag, 2'b01);
    chk("R6 rx pulse", rxIrqPulse, 2'b01);
    @(negedge clk);
    chk("R6 rx pulse single", rxIrqPulse, 2'b00);
    pushRx(0, 8'h22);
    chk("R6 held byte ignores overrun", 32'(rxIrqPulse), 32'h0);
    peek(adr(1, 4'h3), d); chk("R10 B untouched by A rx", d, 8'h00);
    busRead(adr(0, 4'h7), d); chk("R7 read returns held", d, 8'h11);
    peek(adr(0, 4'h3), d); chk("R7 ready cleared", d & 8'h03, 8'h00);
    chk("R7 rx flag cleared", rxIrqFlag, 2'b00);
    busWrite(adr(0, 4'h5), 8'h02);
    pushRx(0, 8'h33);
    peek(adr(0, 4'h3), d); chk("R6 disabled rejects", d & 8'h03, 8'h00);
    peek(adr(0, 4'h7), d); chk("R6 disabled keeps held byte", d, 8'h11);
    chk("R6 disabled no pulse", rxIrqPulse, 2'b00);

    // R3 R4 R5 command sweep: every command from every prior state
    for (int ch = 0; ch < 2; ch++) begin
      for (int pr = 0; pr < 4; pr++) begin
        for (int v = 0; v < 16; v++) begin
          logic rxP, txP, rxE, txE;
          logic [7:0] b;
          rxP = pr[0]; txP = pr[1];
          busWrite(adr(ch, 4'h5), {4'h0, txP ? 2'b01 : 2'b10, rxP ? 2'b01 : 2'b10});
          busRead(adr(ch, 4'h7), d);
          busWrite(adr(ch, 4'h5), 8'(v));
          rxE = fieldNext(2'(v), rxP);
          txE = fieldNext(2'(v >> 2), txP);
          peek(adr(ch, 4'h3), d);
          chk($sformatf("R4 R5 tx bits ch%0d pr%0d v%0h", ch, pr, v), d, {4'h0, txE, txE, 2'b00});
          b = 8'((v << 4) | (pr << 1) | ch);
          pushRx(ch, b);
          peek(adr(ch, 4'h3), d);
          chk($sformatf("R3 R5 rx bits ch%0d pr%0d v%0h", ch, pr, v), d & 8'hF3, {6'h0, rxE, rxE});
          if (rxE) begin
            busRead(adr(ch, 4'h7), d);
            chk($sformatf("R3 R7 byte ch%0d pr%0d v%0h", ch, pr, v), d, b);
          end
        end
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule